// File: doc/BRIEF.md
# Dual-Channel ADC Polling Sequencer

This block sits in front of an existing SPI master and uses it to read a two-channel analog-to-digital converter. When a start request arrives while the block is idle, it issues a channel-0 query. It then issues a channel-1 query, and finally a third transfer that carries the channel-0 command again as a dummy. Each transfer is handshaken with the master. The block waits for busy low, pulses send for one cycle together with the command word, and then waits for busy to go high. Only after that can a new command be launched.

The converter answers each query during the following transfer. For that reason the block captures the received frame at the moment it launches the next query, and it steers the capture to the channel queried one transfer earlier. The frame left over from before the run is discarded. A one-cycle done pulse marks the point where both channel registers hold results from the current request. The block also presents the fixed clock-polarity and clock-phase settings that the master needs.

Top module: `adc_poll_seq`

## Requirements
- R1: After reset, spi_send and done are 0, both channel results are 0 and idle is 1.
- R2: A start request seen while idle launches a first transfer whose spi_tx equals the channel-0 command, 17'h1A000 (binary 11010000000000000).
- R3: spi_send is high for exactly one cycle per transfer, and it is only raised while spi_busy is low.
- R4: After a send, no further send occurs until spi_busy has been seen high and has then returned low.
- R5: Each run launches exactly three transfers, in the order: channel-0 command, channel-1 command 17'h1E000 (binary 11110000000000000), then channel-0 command.
- R6: A captured result is spi_rx bits 11 down to 1, placed in bits 10 down to 0 of the 16-bit register, with bits 15 down to 11 zero.
- R7: The frame present when the channel-1 query is launched goes to ch0_result. The frame present when the final channel-0 query is launched goes to ch1_result. The frame present at the first launch of a run leaves both registers unchanged.
- R8: done is a single-cycle pulse, raised once per run together with the third send. When done is high, both registers hold this run's replies.
- R9: A start request made while a run is in progress has no effect: that run still makes exactly three transfers, and no further transfer follows it.
- R10: spi_clk_idle_high is constantly 0 and spi_late_phase is constantly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one polling run |
| spi_busy | input | 1 | SPI master transfer in progress |
| spi_rx | input | 17 | Frame received by the SPI master |
| spi_send | output | 1 | One-cycle launch pulse to the master |
| spi_tx | output | 17 | Command frame for the master |
| spi_clk_idle_high | output | 1 | Clock polarity setting (0 = idle low) |
| spi_late_phase | output | 1 | Clock phase setting (1 = first edge half a period after select) |
| ch0_result | output | 16 | Latest channel-0 result |
| ch1_result | output | 16 | Latest channel-1 result |
| done | output | 1 | Both results of the current run are ready |
| idle | output | 1 | Sequencer is waiting for a start request |

## Verification
The bench builds the block with its default parameters: a 17-bit frame, a result field from bit 11 to bit 1 widened to 16 bits, and the two command words above. The master model answers with random frames mixed with edge patterns (all ones, only bit 0 set, only bits 11..1 set). These patterns expose both masking and off-by-one field selection. Random latency before busy rises, and random transfer lengths down to a single cycle, bring into reach the cases where the sequencer would otherwise launch two commands on one low phase of busy. Extra start pulses placed in the middle of a run exercise the rule that such requests are ignored.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

  localparam int FRAME_W = 17;
  localparam int RES_W   = 16;
  localparam int RES_HI  = 11;
  localparam int RES_LO  = 1;
  localparam int FIELD_W = RES_HI - RES_LO + 1;
  localparam int N_CH    = 2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISSUE_A = 3'd1,
    ST_ACK_A   = 3'd2,
    ST_ISSUE_B = 3'd3,
    ST_ACK_B   = 3'd4,
    ST_ISSUE_C = 3'd5,
    ST_ACK_C   = 3'd6
  } poll_state_t;

  // Pull the conversion field out of a received frame, zero-widened.
  function automatic logic [RES_W-1:0] res_extract(input logic [FRAME_W-1:0] frame);
    logic [RES_W-1:0] r;
    r = '0;
    r[FIELD_W-1:0] = frame[RES_HI:RES_LO];
    return r;
  endfunction

endpackage

// File: rtl/adc_poll_fsm.sv
module adc_poll_fsm
  import adc_poll_pkg::*;
#(
  parameter logic [FRAME_W-1:0] CMD_CH0 = 17'h1A000,
  parameter logic [FRAME_W-1:0] CMD_CH1 = 17'h1E000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               spi_busy,
  output logic               spi_send,
  output logic [FRAME_W-1:0] spi_tx,
  output logic [N_CH-1:0]    cap,
  output logic               done,
  output logic               idle
);

  poll_state_t st;

  // Named events for the assertions and the result bank.
  logic issue_state;
  logic issue_fire;
  logic seen_hi;

  assign issue_state = (st == ST_ISSUE_A) || (st == ST_ISSUE_B) || (st == ST_ISSUE_C);
  assign issue_fire  = issue_state && !spi_busy;
  assign cap[0]      = (st == ST_ISSUE_B) && !spi_busy;
  assign cap[1]      = (st == ST_ISSUE_C) && !spi_busy;
  assign idle        = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      spi_send <= 1'b0;
      spi_tx   <= '0;
      done     <= 1'b0;
    end else begin
      spi_send <= 1'b0;
      done     <= 1'b0;
      case (st)
        ST_IDLE:    if (start) st <= ST_ISSUE_A;
        ST_ISSUE_A: if (!spi_busy) begin
          spi_tx   <= CMD_CH0;
          spi_send <= 1'b1;
          st       <= ST_ACK_A;
        end
        ST_ACK_A:   if (spi_busy) st <= ST_ISSUE_B;
        ST_ISSUE_B: if (!spi_busy) begin
          spi_tx   <= CMD_CH1;
          spi_send <= 1'b1;
          st       <= ST_ACK_B;
        end
        ST_ACK_B:   if (spi_busy) st <= ST_ISSUE_C;
        ST_ISSUE_C: if (!spi_busy) begin
          spi_tx   <= CMD_CH0;
          spi_send <= 1'b1;
          done     <= 1'b1;
          st       <= ST_ACK_C;
        end
        ST_ACK_C:   if (spi_busy) st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  // Tracks whether busy has been high since the last send.
  always_ff @(posedge clk) begin
    if (!rst_n)        seen_hi <= 1'b1;
    else if (spi_send) seen_hi <= spi_busy;
    else if (spi_busy) seen_hi <= 1'b1;
  end

  assert_send_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_send |=> !spi_send);

  assert_send_busy_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_send) |-> !$past(spi_busy));

  assert_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_send |-> seen_hi);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dummy_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_send && spi_tx == CMD_CH0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !issue_fire && st != ST_ISSUE_A) |=> st != ST_ISSUE_A);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_poll_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CH-1:0]            cap,
  input  logic [FRAME_W-1:0]         rx,
  output logic [N_CH-1:0][RES_W-1:0] res
);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)      res[i] <= '0;
      else if (cap[i]) res[i] <= res_extract(rx);
    end

    assert_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap[i] |=> (res[i][RES_W-1:FIELD_W] == '0));
  end

endmodule

// File: rtl/adc_poll_seq.sv
module adc_poll_seq
  import adc_poll_pkg::*;
#(
  parameter logic [FRAME_W-1:0] CMD_CH0 = 17'h1A000,
  parameter logic [FRAME_W-1:0] CMD_CH1 = 17'h1E000,
  parameter bit                 CPOL    = 1'b0,
  parameter bit                 CPHA    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               spi_busy,
  input  logic [FRAME_W-1:0] spi_rx,
  output logic               spi_send,
  output logic [FRAME_W-1:0] spi_tx,
  output logic               spi_clk_idle_high,
  output logic               spi_late_phase,
  output logic [RES_W-1:0]   ch0_result,
  output logic [RES_W-1:0]   ch1_result,
  output logic               done,
  output logic               idle
);

  logic [N_CH-1:0]            cap;
  logic [N_CH-1:0][RES_W-1:0] res;

  assign spi_clk_idle_high = CPOL;
  assign spi_late_phase    = CPHA;

  adc_poll_fsm #(.CMD_CH0(CMD_CH0), .CMD_CH1(CMD_CH1)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .spi_busy(spi_busy),
    .spi_send(spi_send), .spi_tx(spi_tx), .cap(cap), .done(done), .idle(idle)
  );

  adc_result_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cap(cap), .rx(spi_rx), .res(res)
  );

  assign ch0_result = res[0];
  assign ch1_result = res[1];

  assert_one_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap));

  assert_done_after_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cap[1]));

endmodule

// File: tb/tb_adc_poll_seq.sv
module tb_adc_poll_seq;

  localparam logic [16:0] C0 = 17'h1A000;
  localparam logic [16:0] C1 = 17'h1E000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic spi_busy;
  logic [16:0] spi_rx;
  logic spi_send, spi_clk_idle_high, spi_late_phase, done, idle;
  logic [16:0] spi_tx;
  logic [15:0] ch0_result, ch1_result;

  always #2.5 clk = ~clk;

  adc_poll_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .spi_busy(spi_busy), .spi_rx(spi_rx),
    .spi_send(spi_send), .spi_tx(spi_tx), .spi_clk_idle_high(spi_clk_idle_high),
    .spi_late_phase(spi_late_phase), .ch0_result(ch0_result), .ch1_result(ch1_result),
    .done(done), .idle(idle)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] field_of(input logic [16:0] f);
    return 16'((f >> 1) & 17'h007FF);
  endfunction

  // SPI master model: latency before busy, then a transfer of random length.
  logic [16:0] replies [3];
  int  m_idx = 0;
  bit  m_pend = 0;
  int  m_lat = 0;
  int  m_len = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      spi_busy <= 1'b0;
      spi_rx   <= 17'h15555;
      m_pend   <= 0;
      m_idx    <= 0;
    end else if (spi_send && !m_pend && !spi_busy) begin
      m_pend <= 1;
      m_lat  <= $urandom_range(2, 0);
    end else if (m_pend) begin
      if (m_lat == 0) begin
        m_pend   <= 0;
        spi_busy <= 1'b1;
        m_len    <= $urandom_range(6, 0);
      end else m_lat <= m_lat - 1;
    end else if (spi_busy) begin
      if (m_len == 0) begin
        spi_busy <= 1'b0;
        spi_rx   <= replies[m_idx];
        m_idx    <= (m_idx + 1) % 3;
      end else m_len <= m_len - 1;
    end
  end

  // Monitor
  bit running = 0;
  int nsend = 0;
  int ndone = 0;
  bit prev_send = 0;
  bit seen_hi = 1;
  logic [15:0] prev0 = '0, prev1 = '0;

  always @(negedge clk) begin
    if (rst_n && running) begin
      if (spi_send) begin
        chk(!spi_busy, "R3 send while busy", 32'(spi_busy), 0);
        chk(!prev_send, "R3 send width", 32'(prev_send), 0);
        chk(seen_hi, "R4 handshake", 32'(seen_hi), 1);
        if (nsend == 0) begin
          chk(spi_tx == C0, "R2 first command", 32'(spi_tx), 32'(C0));
          chk(ch0_result == prev0 && ch1_result == prev1, "R7 stale frame ignored",
              {ch0_result, ch1_result}, {prev0, prev1});
        end else
          chk(spi_tx == ((nsend == 1) ? C1 : C0), "R5 command order", 32'(spi_tx),
              32'((nsend == 1) ? C1 : C0));
        nsend++;
        seen_hi = 0;
      end
      if (spi_busy) seen_hi = 1;
      if (done) begin
        chk(nsend == 3, "R8 done with third send", 32'(nsend), 3);
        chk(ch0_result == field_of(replies[0]), "R6 R7 ch0 result", 32'(ch0_result),
            32'(field_of(replies[0])));
        chk(ch1_result == field_of(replies[1]), "R6 R7 ch1 result", 32'(ch1_result),
            32'(field_of(replies[1])));
        ndone++;
      end
    end
    prev_send = spi_send;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_once(input int kind, input bit extra_start);
    case (kind)
      0: begin replies[0] = 17'h1FFFF; replies[1] = 17'h00001; replies[2] = 17'h0ABCD; end
      1: begin replies[0] = 17'h00FFE; replies[1] = 17'h1F001; replies[2] = 17'h00000; end
      default: for (int i = 0; i < 3; i++) replies[i] = 17'($urandom);
    endcase
    nsend = 0;
    ndone = 0;
    running = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      while (nsend < 1) @(negedge clk);
      repeat ($urandom_range(3, 0)) @(negedge clk);
      if (nsend < 3) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    while (!(idle && !spi_busy && !m_pend)) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(nsend == 3, "R9 R5 transfers per run", 32'(nsend), 3);
    chk(ndone == 1, "R8 one done per run", 32'(ndone), 1);
    chk(idle, "R9 back to idle", 32'(idle), 1);
    prev0 = field_of(replies[0]);
    prev1 = field_of(replies[1]);
    running = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    replies[0] = '0; replies[1] = '0; replies[2] = '0;
    repeat (3) @(negedge clk);
    chk(spi_send == 0 && done == 0, "R1 outputs quiet", {spi_send, done}, 0);
    chk(ch0_result == 0 && ch1_result == 0, "R1 results cleared", {ch0_result, ch1_result}, 0);
    chk(idle == 1, "R1 idle", 32'(idle), 1);
    chk(spi_clk_idle_high == 0 && spi_late_phase == 1, "R10 config",
        {spi_clk_idle_high, spi_late_phase}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_send == 0 && idle == 1, "R1 no activity without start", {spi_send, idle}, 1);
    run_once(0, 0);
    run_once(1, 1);
    for (int r = 0; r < 40; r++) run_once(2, (r % 3) == 0);
    chk(spi_clk_idle_high == 0 && spi_late_phase == 1, "R10 config end",
        {spi_clk_idle_high, spi_late_phase}, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule